// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit with 64-bit Accumulator

This block multiplies two signed operands and adds the product into a 64-bit accumulator kept as a high word and a low word of 32 bits each. A mode input picks the operand width. In long mode, both full 32-bit inputs are signed multiplicands. In word mode, only the low 16 bits of each input are used, as signed values. Either way, the product is sign-extended to 64 bits and added to the whole accumulator.

A saturation-enable input changes how the sum is written back, and the two modes differ. Long mode limits the result to 48 significant bits by rewriting only the high word. Word mode clips to the signed 32-bit range and puts the value 1 into the high word as an overflow marker. With saturation off, the 64-bit sum wraps and is stored unchanged.

Each accumulation takes one cycle. The updated accumulator is visible, with a one-cycle done pulse, after the clock edge that samples the start strobe. A clear input and two word-write ports let the surrounding datapath set the accumulator directly.

Top module: `mac_sat64`

## Requirements
- R1: While reset is asserted, and after it is released, both accumulator words read 0 and `done_o` is 0.
- R2: With `mode_i`=0 (long) and `sat_en_i`=0, a start adds the signed 64-bit product of `opa_i` and `opb_i` to the value {`acc_hi_o`,`acc_lo_o`}, wrapping modulo 2^64.
- R3: With `mode_i`=1 (word), the multiplicands are `opa_i[15:0]` and `opb_i[15:0]` taken as signed. Bits 31:16 of the operands have no effect on the result.
- R4: Long mode with saturation, 64-bit sum negative: bits 31:16 of the high word are forced to 1, bits 15:0 of the high word and the whole low word keep the sum's value.
- R5: Long mode with saturation, 64-bit sum non-negative: the high word keeps only bits 14:0 of the sum's high word, and the low word keeps the sum's value.
- R6: Word mode with saturation, 64-bit sum greater than 2^31-1: the high word becomes 1 and the low word becomes 0x7FFFFFFF.
- R7: Word mode with saturation, 64-bit sum less than -2^31: the high word becomes 1 and the low word becomes 0x80000000. A sum inside the signed 32-bit range is stored unchanged.
- R8: The result of a start appears at the outputs after the first rising clock edge that samples `start_i`. `done_o` is high for exactly that one cycle for each accepted start.
- R9: Starts on consecutive cycles each accumulate onto the result of the previous one.
- R10: `clr_i` zeroes both words at the next edge. It has priority over a start and over the write ports in the same cycle, and a start that is overridden this way produces no done pulse.
- R11: `wr_hi_en_i` loads `wr_data_i` into the high word and `wr_lo_en_i` loads it into the low word at the next edge. Both are ignored in a cycle with `start_i` or `clr_i`.
- R12: With no start, clear or write, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Starts one multiply-accumulate |
| mode_i | input | 1 | 0 = long (32x32), 1 = word (16x16) |
| sat_en_i | input | 1 | Enables saturating write-back |
| opa_i | input | 32 | First multiplicand |
| opb_i | input | 32 | Second multiplicand |
| clr_i | input | 1 | Zeroes the accumulator |
| wr_hi_en_i | input | 1 | Loads the high word from wr_data_i |
| wr_lo_en_i | input | 1 | Loads the low word from wr_data_i |
| wr_data_i | input | 32 | Write data for the accumulator words |
| acc_hi_o | output | 32 | Accumulator high word |
| acc_lo_o | output | 32 | Accumulator low word |
| done_o | output | 1 | One-cycle pulse when a result is written |

## Verification
The bench preloads the accumulator next to each saturation threshold and then crosses it in both directions in both modes. A design that applied the word-mode clip in long mode, or masked the wrong high-word bits, would leave the accumulator off by a large amount. It drives word-mode operands with non-zero upper halves, which exposes any leak of bits 31:16 into the 16-bit product. It also issues back-to-back starts and starts that collide with a clear or a write. A stale accumulator read would lose a product, and a wrong priority would let a write or a stray done pulse through.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_WORD = 1'b1
  } mac_mode_e;

endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mac_mul.sv
module mac_mul
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  mac_mode_e        mode,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  output logic [2*W-1:0]   prod
);

  localparam int HALF = W / 2;
  localparam int PW   = 2 * W;

  logic [W-1:0]  ext_a, ext_b;
  logic [PW-1:0] wide_a, wide_b;

  // word mode narrows each operand to its signed low half
  always_comb begin
    if (mode == MODE_WORD) begin
      ext_a = {{(W-HALF){opa[HALF-1]}}, opa[HALF-1:0]};
      ext_b = {{(W-HALF){opb[HALF-1]}}, opb[HALF-1:0]};
    end else begin
      ext_a = opa;
      ext_b = opb;
    end
  end

  // sign-extend to product width; low PW bits of the unsigned product are exact
  assign wide_a = {{W{ext_a[W-1]}}, ext_a};
  assign wide_b = {{W{ext_b[W-1]}}, ext_b};
  assign prod   = wide_a * wide_b;

endmodule

// File: rtl/mac_sat.sv
module mac_sat
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  mac_mode_e        mode,
  input  logic             sat_en,
  input  logic [2*W-1:0]   sum,
  output logic [W-1:0]     res_hi,
  output logic [W-1:0]     res_lo
);

  localparam int HALF = W / 2;
  localparam logic [W-1:0] HI_NEG_SET  = {{HALF{1'b1}}, {(W-HALF){1'b0}}};
  localparam logic [W-1:0] HI_POS_KEEP = {{(W-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [W-1:0] LIM_POS     = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] LIM_NEG     = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] OVF_MARK    = W'(1);

  logic         neg;
  logic [W:0]   top_bits;
  logic         above, below;
  logic [W-1:0] sum_hi, sum_lo;

  assign sum_hi   = sum[2*W-1:W];
  assign sum_lo   = sum[W-1:0];
  assign neg      = sum[2*W-1];
  assign top_bits = sum[2*W-1:W-1];
  // outside the signed W-bit range when the top W+1 bits are not a sign run
  assign above    = !neg && (|top_bits);
  assign below    = neg && !(&top_bits);

  always_comb begin
    res_hi = sum_hi;
    res_lo = sum_lo;
    if (sat_en) begin
      if (mode == MODE_LONG) begin
        if (neg) res_hi = sum_hi | HI_NEG_SET;
        else     res_hi = sum_hi & HI_POS_KEEP;
      end else begin
        if (above) begin
          res_hi = OVF_MARK;
          res_lo = LIM_POS;
        end else if (below) begin
          res_hi = OVF_MARK;
          res_lo = LIM_NEG;
        end
      end
    end
  end

endmodule

// File: rtl/mac_sat64.sv
module mac_sat64
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic         sat_en_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         clr_i,
  input  logic         wr_hi_en_i,
  input  logic         wr_lo_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] acc_hi_o,
  output logic [W-1:0] acc_lo_o,
  output logic         done_o
);

  localparam int AW = 2 * W;

  logic          rst_sync_n;
  mac_mode_e     mode;
  logic [AW-1:0] prod, sum;
  logic [W-1:0]  sat_hi, sat_lo;
  logic [W-1:0]  hi_q, lo_q, hi_d, lo_d;
  logic          done_q, done_d;
  logic          acc_en;

  assign mode = mac_mode_e'(mode_i);

  mac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mac_mul #(.W(W)) u_mul (
    .mode (mode),
    .opa  (opa_i),
    .opb  (opb_i),
    .prod (prod)
  );

  assign sum = {hi_q, lo_q} + prod;

  mac_sat #(.W(W)) u_sat (
    .mode   (mode),
    .sat_en (sat_en_i),
    .sum    (sum),
    .res_hi (sat_hi),
    .res_lo (sat_lo)
  );

  // next state: clear > start > word writes
  assign acc_en = clr_i | start_i | wr_hi_en_i | wr_lo_en_i;

  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    done_d = 1'b0;
    if (clr_i) begin
      hi_d = '0;
      lo_d = '0;
    end else if (start_i) begin
      hi_d   = sat_hi;
      lo_d   = sat_lo;
      done_d = 1'b1;
    end else begin
      if (wr_hi_en_i) hi_d = wr_data_i;
      if (wr_lo_en_i) lo_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (acc_en) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
      done_q <= done_d;
    end
  end

  assign acc_hi_o = hi_q;
  assign acc_lo_o = lo_q;
  assign done_o   = done_q;

endmodule

// File: rtl/mac_sat64_chk.sv
module mac_sat64_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         start_i,
  input logic         mode_i,
  input logic         sat_en_i,
  input logic         clr_i,
  input logic         wr_hi_en_i,
  input logic         wr_lo_en_i,
  input logic [W-1:0] wr_data_i,
  input logic [W-1:0] acc_hi_o,
  input logic [W-1:0] acc_lo_o,
  input logic         done_o
);

  localparam int HALF = W / 2;
  localparam logic [W-1:0] LIM_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] LIM_NEG = {1'b1, {(W-1){1'b0}}};

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    clr_i |=> (acc_hi_o == '0) && (acc_lo_o == '0));

  // R8
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (start_i && !clr_i) |=> done_o);

  // R8
  no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(start_i && !clr_i) |=> !done_o);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(start_i || clr_i || wr_hi_en_i || wr_lo_en_i)
      |=> $stable(acc_hi_o) && $stable(acc_lo_o));

  // R11
  write_hi_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_hi_en_i && !start_i && !clr_i) |=> acc_hi_o == $past(wr_data_i));

  // R11
  write_lo_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_lo_en_i && !start_i && !clr_i) |=> acc_lo_o == $past(wr_data_i));

  // R4
  long_sat_form_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (start_i && !clr_i && !mode_i && sat_en_i)
      |=> (&acc_hi_o[W-1:HALF]) || (acc_hi_o[W-1:HALF-1] == '0));

  // R6
  word_sat_range_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (start_i && !clr_i && mode_i && sat_en_i)
      |=> (acc_hi_o == {W{acc_lo_o[W-1]}}) ||
          ((acc_hi_o == W'(1)) && ((acc_lo_o == LIM_POS) || (acc_lo_o == LIM_NEG))));

endmodule

bind mac_sat64 mac_sat64_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .sat_en_i   (sat_en_i),
  .clr_i      (clr_i),
  .wr_hi_en_i (wr_hi_en_i),
  .wr_lo_en_i (wr_lo_en_i),
  .wr_data_i  (wr_data_i),
  .acc_hi_o   (acc_hi_o),
  .acc_lo_o   (acc_lo_o),
  .done_o     (done_o)
);

// File: tb/sim_mac_sat64.sv
`timescale 1ns/1ps
module sim_mac_sat64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, mode_i, sat_en_i, clr_i, wr_hi_en_i, wr_lo_en_i;
  logic [31:0] opa_i, opb_i, wr_data_i;
  logic [31:0] acc_hi_o, acc_lo_o;
  logic        done_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // reference state
  longint mdl_acc;
  bit     mdl_done;

  always #10 clk = ~clk;

  mac_sat64 u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .sat_en_i(sat_en_i), .opa_i(opa_i), .opb_i(opb_i), .clr_i(clr_i),
    .wr_hi_en_i(wr_hi_en_i), .wr_lo_en_i(wr_lo_en_i), .wr_data_i(wr_data_i),
    .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .done_o(done_o)
  );

  function automatic longint ref_step(longint acc, bit md, bit sat,
                                      logic [31:0] a, logic [31:0] b);
    longint pa, pb, s;
    logic [31:0] hi;
    if (md) begin
      pa = longint'(shortint'(a[15:0]));
      pb = longint'(shortint'(b[15:0]));
    end else begin
      pa = longint'(int'(a));
      pb = longint'(int'(b));
    end
    s = acc + pa * pb;
    if (!sat) return s;
    if (!md) begin
      hi = s[63:32];
      if (s < 0) hi = hi | 32'hFFFF0000;
      else       hi = hi & 32'h00007FFF;
      return {hi, s[31:0]};
    end
    if (s > 64'sd2147483647)  return {32'd1, 32'h7FFFFFFF};
    if (s < -64'sd2147483648) return {32'd1, 32'h80000000};
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mdl_acc  <= 0;
      mdl_done <= 1'b0;
    end else begin
      mdl_done <= start_i && !clr_i;
      if (clr_i) mdl_acc <= 0;
      else if (start_i) mdl_acc <= ref_step(mdl_acc, mode_i, sat_en_i, opa_i, opb_i);
      else begin
        if (wr_hi_en_i) mdl_acc[63:32] <= wr_data_i;
        if (wr_lo_en_i) mdl_acc[31:0]  <= wr_data_i;
      end
    end
  end

  task automatic check(string req, bit ok, string what,
                       logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare design with model; called at a negative edge
  task automatic compare();
    check(cur_req, {acc_hi_o, acc_lo_o} == mdl_acc, "accumulator",
          {acc_hi_o, acc_lo_o}, mdl_acc);
    check(cur_req, done_o == mdl_done, "done", 64'(done_o), 64'(mdl_done));
  endtask

  task automatic idle_inputs();
    start_i = 0; mode_i = 0; sat_en_i = 0; clr_i = 0;
    wr_hi_en_i = 0; wr_lo_en_i = 0;
    opa_i = '0; opb_i = '0; wr_data_i = '0;
  endtask

  // one clock with the given inputs; compare after the edge
  task automatic cyc(bit st, bit md, bit sat, logic [31:0] a, logic [31:0] b,
                     bit clr, bit whi, bit wlo, logic [31:0] wd);
    start_i = st; mode_i = md; sat_en_i = sat; opa_i = a; opb_i = b;
    clr_i = clr; wr_hi_en_i = whi; wr_lo_en_i = wlo; wr_data_i = wd;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    compare();
  endtask

  task automatic mac(bit md, bit sat, logic [31:0] a, logic [31:0] b);
    cyc(1, md, sat, a, b, 0, 0, 0, '0);
  endtask

  task automatic load(logic [31:0] hi, logic [31:0] lo);
    cyc(0, 0, 0, '0, '0, 0, 1, 0, hi);
    cyc(0, 0, 0, '0, '0, 0, 0, 1, lo);
  endtask

  task automatic expect_acc(string req, logic [31:0] hi, logic [31:0] lo);
    check(req, {acc_hi_o, acc_lo_o} == {hi, lo}, "fixed value",
          {acc_hi_o, acc_lo_o}, {hi, lo});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0, '0, '0, 0, 0, 0, '0);
    expect_acc("R1", 32'h0, 32'h0);

    // R2 long mode, no saturation, mixed signs
    cur_req = "R2";
    mac(0, 0, 32'd1000, 32'd2000);
    expect_acc("R2", 32'h0, 32'd2000000);
    mac(0, 0, 32'hFFFFFFFF, 32'd5);
    mac(0, 0, 32'h80000000, 32'h80000000);
    mac(0, 0, 32'h7FFFFFFF, 32'h80000001);
    load(32'h7FFFFFFF, 32'hFFFFFFFF);
    mac(0, 0, 32'd1, 32'd1);
    expect_acc("R2", 32'h80000000, 32'h0);

    // R3 word mode ignores upper operand halves
    cur_req = "R3";
    cyc(0, 0, 0, '0, '0, 1, 0, 0, '0);
    mac(1, 0, 32'hABCD0003, 32'h1234FFFE);
    expect_acc("R3", 32'hFFFFFFFF, 32'hFFFFFFFA);
    mac(1, 0, 32'h00008000, 32'hFFFF8000);
    mac(1, 0, 32'h55557FFF, 32'hAAAA7FFF);

    // R4 long saturation, negative sum
    cur_req = "R4";
    load(32'h00001234, 32'h0);
    mac(0, 1, 32'hFFFFFFFF, 32'h7FFFFFFF);
    load(32'h80000000, 32'h00000010);
    mac(0, 1, 32'd3, 32'd4);
    expect_acc("R4", 32'hFFFF0000, 32'h0000001C);

    // R5 long saturation, non-negative sum
    cur_req = "R5";
    load(32'h7FFF0000, 32'h00000001);
    mac(0, 1, 32'd2, 32'd2);
    expect_acc("R5", 32'h0, 32'h00000005);
    load(32'h0000ABCD, 32'h0);
    mac(0, 1, 32'h40000000, 32'h00000004);

    // R6 word saturation above range
    cur_req = "R6";
    load(32'h0, 32'h7FFFFFF0);
    mac(1, 1, 32'd100, 32'd100);
    expect_acc("R6", 32'h1, 32'h7FFFFFFF);
    load(32'h0, 32'h7FFFFF00);
    mac(1, 1, 32'd15, 32'd17);

    // R7 word saturation below range and in range
    cur_req = "R7";
    load(32'hFFFFFFFF, 32'h80000000);
    mac(1, 1, 32'hFFFFFFFF, 32'd1);
    expect_acc("R7", 32'h1, 32'h80000000);
    load(32'hFFFFFFFF, 32'h80000010);
    mac(1, 1, 32'hFFFFFFFF, 32'h10);
    expect_acc("R7", 32'hFFFFFFFF, 32'h80000000);
    load(32'h0, 32'h10);
    mac(1, 1, 32'hFFFF8000, 32'h7FFF);

    // R8 done pulse exactly one cycle
    cur_req = "R8";
    cyc(0, 0, 0, '0, '0, 1, 0, 0, '0);
    mac(0, 0, 32'd7, 32'd6);
    check("R8", done_o == 1'b1, "done after start", 64'(done_o), 64'd1);
    expect_acc("R8", 32'h0, 32'd42);
    cyc(0, 0, 0, '0, '0, 0, 0, 0, '0);
    check("R8", done_o == 1'b0, "done drops", 64'(done_o), 64'd0);

    // R9 back-to-back starts
    cur_req = "R9";
    for (int i = 1; i <= 6; i++)
      mac(i[0], i[1], 32'(i * 300001), 32'(-i * 70003));
    cyc(0, 0, 0, '0, '0, 1, 0, 0, '0);
    for (int i = 0; i < 4; i++) mac(0, 0, 32'd10, 32'd10);
    expect_acc("R9", 32'h0, 32'd400);

    // R10 clear beats start and writes
    cur_req = "R10";
    cyc(1, 0, 0, 32'd9, 32'd9, 1, 1, 1, 32'hDEADBEEF);
    expect_acc("R10", 32'h0, 32'h0);
    check("R10", done_o == 1'b0, "no done on cleared start", 64'(done_o), 64'd0);

    // R11 writes, ignored under a start
    cur_req = "R11";
    cyc(0, 0, 0, '0, '0, 0, 1, 1, 32'h13572468);
    expect_acc("R11", 32'h13572468, 32'h13572468);
    load(32'h0, 32'h5);
    cyc(1, 0, 0, 32'd2, 32'd3, 0, 1, 1, 32'hFFFFFFFF);
    expect_acc("R11", 32'h0, 32'd11);

    // R12 hold while idle
    cur_req = "R12";
    repeat (5) cyc(0, 1, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 32'hFFFFFFFF);
    expect_acc("R12", 32'h0, 32'd11);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule